// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a controller that thinks in whole flash operations and a generic single-beat bus master that reaches a parallel NOR flash. A caller presents one request (an opcode, a target address and a data word). The block expands it into the exact series of command writes the flash needs: unlock cycles, a command code and the final address or data beat. For the identifier and query operations it then reads back four words and presents them on a flat result vector.

Each bus beat holds request, direction, address and write data until the flash side acknowledges it. Only then does the block move to the next beat. A one-cycle done pulse marks the end of an operation. A controller-level write-protect state refuses program and erase requests with an error pulse but still allows the read-type operations. A request that arrives while an operation is running is refused with a one-cycle reject pulse, and the running operation carries on untouched. The parameter `BYTE_ADDR` scales every fixed command address (and the fixed read addresses) by two, for a 16-bit device behind byte addressing. Caller-supplied target addresses are never scaled.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is asserted, `state_o` is 0 (reset state), and `busy_o`, `done_o`, `err_o`, `rej_o` and `bus_req_o` are all 0. On the first clock edge after reset is released, `state_o` becomes 1 (ready). The other state codes are 2 (busy) and 3 (write-protected).
- R2: Every unlock pair is two writes: 0xAA to command address 0x555, then 0x55 to command address 0x2AA. A command address A appears on `bus_addr_o` as A shifted left by `BYTE_ADDR` bits.
- R3: Opcode 0 (identifier read) writes the unlock pair and then 0x90 to 0x555. It then performs four reads at command addresses 0x00, 0x01, 0x0E and 0x0F. The k-th word read lands in `rd_data_o[k*DW +: DW]`.
- R4: Opcode 2 (program) writes the unlock pair, then 0xA0 to 0x555, then `req_data_i` to the unshifted `req_addr_i`. That is four writes.
- R5: Opcode 3 (block erase) performs six writes: the unlock pair, 0x80 to 0x555, the unlock pair again, then 0x30 to the unshifted `req_addr_i`.
- R6: Opcode 4 (chip erase) performs the same first five writes as R5, and its sixth write is 0x10 to command address 0x555.
- R7: Opcode 1 (return to read mode) is exactly one write of 0xF0 to command address 0x000.
- R8: Opcode 5 (query) is one write of 0x98 to command address 0x055. It is followed by reads at command addresses 0x10 to 0x13, stored as in R3.
- R9: During a beat, `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` stay constant until a cycle with `bus_ack_i` high. The next beat starts only after that cycle, and any number of wait cycles is tolerated.
- R10: `busy_o` is 1 from the cycle after a bus operation is accepted. `done_o` is 1 for exactly one cycle: the cycle after the acknowledge of the last beat. In that cycle `busy_o` is 0.
- R11: A request presented while `busy_o` is 1 gives a one-cycle `rej_o` pulse in the next cycle. The running operation's beats are unchanged, and the refused operation issues no beats.
- R12: Opcode 6 enters the write-protected state (3) and opcode 7 returns to ready (1); each gives a done pulse and no bus beat. While protected, opcodes 2, 3 and 4 give a one-cycle `err_o` pulse, issue no bus beat, and leave the state at 3.
- R13: While protected, opcodes 0, 1 and 5 run normally. The state returns to 3 when they complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, sampled each clock |
| req_op_i | input | 3 | Operation code (R3 to R8, R12) |
| req_addr_i | input | AW | Target address for program and block erase |
| req_data_i | input | DW | Data word for program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse: modifying request refused while protected |
| rej_o | output | 1 | One-cycle pulse: request refused while busy |
| state_o | output | 2 | 0 reset, 1 ready, 2 busy, 3 protected |
| rd_data_o | output | 4*DW | Four words from the last identifier or query read |
| bus_req_o | output | 1 | Bus beat request |
| bus_we_o | output | 1 | Beat direction, 1 = write |
| bus_addr_o | output | AW | Beat address |
| bus_wdata_o | output | DW | Beat write data |
| bus_ack_i | input | 1 | Beat acknowledge |
| bus_rdata_i | input | DW | Read data, valid with the acknowledge |

## Verification
The bench puts each operation on a bus model with zero and non-zero wait states. It compares every logged beat against the command tables, with the address scaling applied. A sequencer that advanced on request rather than on acknowledge, or that scaled the caller's target address, would show wrong or missing beats. The bench also issues a second request in the middle of a program operation. A design that aborted or queued that request would log extra beats or change the program's beats. Protection is exercised with both refused and permitted opcodes. A design that let an erase through, or that came back to ready after a permitted read while still protected, would be caught by the beat count or by the final state.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_IDREAD = 3'd0,
        OP_RDMODE = 3'd1,
        OP_PROG   = 3'd2,
        OP_BERASE = 3'd3,
        OP_CERASE = 3'd4,
        OP_QUERY  = 3'd5,
        OP_LOCK   = 3'd6,
        OP_UNLOCK = 3'd7
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_READY = 2'd1,
        ST_BUSY  = 2'd2,
        ST_PROT  = 2'd3
    } seq_state_e;

    // Fixed command addresses, in device word units before scaling.
    localparam logic [11:0] CA_FIRST  = 12'h555;
    localparam logic [11:0] CA_SECOND = 12'h2AA;
    localparam logic [11:0] CA_QUERY  = 12'h055;
    localparam logic [11:0] CA_BASE   = 12'h000;

    // Command codes.
    localparam logic [7:0] CD_KEY1   = 8'hAA;
    localparam logic [7:0] CD_KEY2   = 8'h55;
    localparam logic [7:0] CD_IDENT  = 8'h90;
    localparam logic [7:0] CD_PROG   = 8'hA0;
    localparam logic [7:0] CD_ERSET  = 8'h80;
    localparam logic [7:0] CD_BLOCK  = 8'h30;
    localparam logic [7:0] CD_CHIP   = 8'h10;
    localparam logic [7:0] CD_RDMODE = 8'hF0;
    localparam logic [7:0] CD_QUERY  = 8'h98;

    localparam int unsigned N_RD_WORDS = 4;

    function automatic logic [11:0] ident_word_addr(input logic [1:0] slot);
        case (slot)
            2'd0:    return 12'h000;
            2'd1:    return 12'h001;
            2'd2:    return 12'h00E;
            default: return 12'h00F;
        endcase
    endfunction

    function automatic logic [11:0] query_word_addr(input logic [1:0] slot);
        return 12'h010 + {10'd0, slot};
    endfunction

endpackage

// File: rtl/nor_step_gen.sv
module nor_step_gen
    import nor_seq_pkg::*;
#(
    parameter int unsigned AW        = 24,
    parameter int unsigned DW        = 16,
    parameter int unsigned BYTE_ADDR = 1,
    parameter int unsigned IDXW      = 3
) (
    input  seq_op_e          op_i,
    input  logic [IDXW-1:0]  idx_i,
    input  logic [AW-1:0]    tgt_addr_i,
    input  logic [DW-1:0]    tgt_data_i,
    output logic             we_o,
    output logic [AW-1:0]    addr_o,
    output logic [DW-1:0]    data_o,
    output logic             last_o,
    output logic [1:0]       slot_o
);

    function automatic logic [AW-1:0] cmd_addr(input logic [11:0] a);
        return AW'(a) << BYTE_ADDR;
    endfunction

    function automatic logic [DW-1:0] cmd_data(input logic [7:0] d);
        return DW'(d);
    endfunction

    logic [1:0] rd_slot;
    assign rd_slot = 2'(idx_i - IDXW'(3));

    always_comb begin
        we_o   = 1'b1;
        addr_o = '0;
        data_o = '0;
        last_o = 1'b0;
        slot_o = 2'd0;
        unique case (op_i)
            OP_IDREAD: begin
                case (idx_i)
                    IDXW'(0): begin addr_o = cmd_addr(CA_FIRST);  data_o = cmd_data(CD_KEY1);  end
                    IDXW'(1): begin addr_o = cmd_addr(CA_SECOND); data_o = cmd_data(CD_KEY2);  end
                    IDXW'(2): begin addr_o = cmd_addr(CA_FIRST);  data_o = cmd_data(CD_IDENT); end
                    default: begin
                        we_o   = 1'b0;
                        slot_o = rd_slot;
                        addr_o = cmd_addr(ident_word_addr(rd_slot));
                        last_o = (rd_slot == 2'd3);
                    end
                endcase
            end
            OP_QUERY: begin
                if (idx_i == IDXW'(0)) begin
                    addr_o = cmd_addr(CA_QUERY);
                    data_o = cmd_data(CD_QUERY);
                end else begin
                    we_o   = 1'b0;
                    slot_o = 2'(idx_i - IDXW'(1));
                    addr_o = cmd_addr(query_word_addr(2'(idx_i - IDXW'(1))));
                    last_o = (idx_i == IDXW'(4));
                end
            end
            OP_RDMODE: begin
                addr_o = cmd_addr(CA_BASE);
                data_o = cmd_data(CD_RDMODE);
                last_o = 1'b1;
            end
            OP_PROG: begin
                case (idx_i)
                    IDXW'(0): begin addr_o = cmd_addr(CA_FIRST);  data_o = cmd_data(CD_KEY1); end
                    IDXW'(1): begin addr_o = cmd_addr(CA_SECOND); data_o = cmd_data(CD_KEY2); end
                    IDXW'(2): begin addr_o = cmd_addr(CA_FIRST);  data_o = cmd_data(CD_PROG); end
                    default: begin
                        addr_o = tgt_addr_i;
                        data_o = tgt_data_i;
                        last_o = 1'b1;
                    end
                endcase
            end
            OP_BERASE, OP_CERASE: begin
                case (idx_i)
                    IDXW'(0), IDXW'(3): begin addr_o = cmd_addr(CA_FIRST);  data_o = cmd_data(CD_KEY1);  end
                    IDXW'(1), IDXW'(4): begin addr_o = cmd_addr(CA_SECOND); data_o = cmd_data(CD_KEY2);  end
                    IDXW'(2):           begin addr_o = cmd_addr(CA_FIRST);  data_o = cmd_data(CD_ERSET); end
                    default: begin
                        last_o = 1'b1;
                        if (op_i == OP_BERASE) begin
                            addr_o = tgt_addr_i;
                            data_o = cmd_data(CD_BLOCK);
                        end else begin
                            addr_o = cmd_addr(CA_FIRST);
                            data_o = cmd_data(CD_CHIP);
                        end
                    end
                endcase
            end
            default: begin
                last_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/nor_rd_bank.sv
module nor_rd_bank #(
    parameter int unsigned DW     = 16,
    parameter int unsigned NWORDS = 4,
    localparam int unsigned SW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cap_en_i,
    input  logic [SW-1:0]        slot_i,
    input  logic [DW-1:0]        rdata_i,
    output logic [NWORDS*DW-1:0] words_o
);

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                word_q <= '0;
            end else if (cap_en_i && (slot_i == SW'(k))) begin
                word_q <= rdata_i;
            end
        end
        assign words_o[k*DW +: DW] = word_q;
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int unsigned AW        = 24,
    parameter int unsigned DW        = 16,
    parameter int unsigned BYTE_ADDR = 1
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         req_valid_i,
    input  logic [2:0]                   req_op_i,
    input  logic [AW-1:0]                req_addr_i,
    input  logic [DW-1:0]                req_data_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         err_o,
    output logic                         rej_o,
    output logic [1:0]                   state_o,
    output logic [N_RD_WORDS*DW-1:0]     rd_data_o,
    output logic                         bus_req_o,
    output logic                         bus_we_o,
    output logic [AW-1:0]                bus_addr_o,
    output logic [DW-1:0]                bus_wdata_o,
    input  logic                         bus_ack_i,
    input  logic [DW-1:0]                bus_rdata_i
);

    localparam int unsigned IDXW = 3;

    typedef struct packed {
        seq_state_e      st;
        seq_op_e         op;
        logic [IDXW-1:0] idx;
        logic [AW-1:0]   tgt;
        logic [DW-1:0]   wd;
        logic            prot;
        logic            done;
        logic            err;
        logic            rej;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          beat_we;
    logic [AW-1:0] beat_addr;
    logic [DW-1:0] beat_data;
    logic          beat_last;
    logic [1:0]    beat_slot;
    logic          in_op;
    logic          beat_fire;

    nor_step_gen #(
        .AW        (AW),
        .DW        (DW),
        .BYTE_ADDR (BYTE_ADDR),
        .IDXW      (IDXW)
    ) u_step (
        .op_i       (r_q.op),
        .idx_i      (r_q.idx),
        .tgt_addr_i (r_q.tgt),
        .tgt_data_i (r_q.wd),
        .we_o       (beat_we),
        .addr_o     (beat_addr),
        .data_o     (beat_data),
        .last_o     (beat_last),
        .slot_o     (beat_slot)
    );

    assign in_op     = (r_q.st == ST_BUSY);
    assign beat_fire = in_op && bus_ack_i;

    nor_rd_bank #(
        .DW     (DW),
        .NWORDS (N_RD_WORDS)
    ) u_rd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cap_en_i (beat_fire && !beat_we),
        .slot_i   (beat_slot),
        .rdata_i  (bus_rdata_i),
        .words_o  (rd_data_o)
    );

    always_comb begin
        seq_op_e new_op;
        logic    modifying;

        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        r_d.rej  = 1'b0;
        new_op    = seq_op_e'(req_op_i);
        modifying = (new_op == OP_PROG) || (new_op == OP_BERASE) || (new_op == OP_CERASE);

        if (r_q.st == ST_RESET) begin
            r_d.st = ST_READY;
        end

        if (in_op) begin
            if (req_valid_i) begin
                r_d.rej = 1'b1;
            end
            if (bus_ack_i) begin
                if (beat_last) begin
                    r_d.st   = r_q.prot ? ST_PROT : ST_READY;
                    r_d.done = 1'b1;
                    r_d.idx  = '0;
                end else begin
                    r_d.idx = r_q.idx + IDXW'(1);
                end
            end
        end else if (req_valid_i) begin
            unique case (new_op)
                OP_LOCK: begin
                    r_d.prot = 1'b1;
                    r_d.st   = ST_PROT;
                    r_d.done = 1'b1;
                end
                OP_UNLOCK: begin
                    r_d.prot = 1'b0;
                    r_d.st   = ST_READY;
                    r_d.done = 1'b1;
                end
                default: begin
                    if (modifying && r_q.prot) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st  = ST_BUSY;
                        r_d.op  = new_op;
                        r_d.idx = '0;
                        r_d.tgt = req_addr_i;
                        r_d.wd  = req_data_i;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_RESET, op: OP_RDMODE, idx: '0, tgt: '0, wd: '0,
                     prot: 1'b0, done: 1'b0, err: 1'b0, rej: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = in_op;
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign rej_o       = r_q.rej;
    assign state_o     = r_q.st;
    assign bus_req_o   = in_op;
    assign bus_we_o    = in_op && beat_we;
    assign bus_addr_o  = in_op ? beat_addr : '0;
    assign bus_wdata_o = (in_op && beat_we) ? beat_data : '0;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int unsigned AW = 24,
    parameter int unsigned DW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [1:0]    state_o,
    input logic          bus_req_o,
    input logic          bus_we_o,
    input logic [AW-1:0] bus_addr_o,
    input logic [DW-1:0] bus_wdata_o,
    input logic          bus_ack_i
);

    a_r1_leave_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == 2'd0 |=> state_o == 2'd1);

    a_r9_beat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o)
                                       && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o && !bus_req_o);

    a_r12_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !bus_req_o && !done_o && state_o == 2'd3);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .state_o     (state_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/nor_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int BA = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, done, err, rej;
    logic [1:0]    state;
    logic [4*DW-1:0] rd_data;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;

    logic [AW-1:0] lg_a [0:15];
    logic [DW-1:0] lg_d [0:15];
    logic          lg_w [0:15];
    int lg_n     = 0;
    int wait_cfg = 0;
    int wcnt     = 0;

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .DW(DW), .BYTE_ADDR(BA)) dut_i (
        .clk_i (clk), .rst_ni (rst_n),
        .req_valid_i (req_valid), .req_op_i (req_op),
        .req_addr_i (req_addr), .req_data_i (req_data),
        .busy_o (busy), .done_o (done), .err_o (err), .rej_o (rej),
        .state_o (state), .rd_data_o (rd_data),
        .bus_req_o (bus_req), .bus_we_o (bus_we),
        .bus_addr_o (bus_addr), .bus_wdata_o (bus_wdata),
        .bus_ack_i (bus_ack), .bus_rdata_i (bus_rdata)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return 16'h5A00 ^ a[15:0];
    endfunction

    function automatic logic [AW-1:0] sh(input int a);
        return AW'(a) << BA;
    endfunction

    // Flash-side model: acknowledges after wait_cfg idle cycles and logs beats.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if (bus_req) begin
            if (wcnt >= wait_cfg) begin
                if (lg_n < 16) begin
                    lg_a[lg_n] = bus_addr;
                    lg_d[lg_n] = bus_wdata;
                    lg_w[lg_n] = bus_we;
                end
                lg_n++;
                bus_rdata = mem_word(bus_addr);
                bus_ack = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic beat(input string tag, input int i, input logic w,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk({tag, " dir"},  64'(lg_w[i]), 64'(w));
        chk({tag, " addr"}, 64'(lg_a[i]), 64'(a));
        if (w) chk({tag, " data"}, 64'(lg_d[i]), 64'(d));
    endtask

    task automatic send(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        lg_n = 0;
        req_op = 3'(op); req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done seen"}, 64'(done), 64'd1);
        chk({tag, " not busy at done"}, 64'(busy), 64'd0);
        @(negedge clk);
        chk({tag, " done one cycle"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 state in reset", 64'(state), 64'd0);
        chk("R1 outputs in reset", 64'({busy, done, err, rej, bus_req}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 64'(state), 64'd1);
    endtask

    task automatic t_idread;
        wait_cfg = 0;
        send(0, '0, '0);
        chk("R10 busy after accept", 64'(busy), 64'd1);
        wait_done("R10 id");
        chk("R3 beat count", 64'(lg_n), 64'd7);
        beat("R2 key1", 0, 1, sh(12'h555), 16'hAA);
        beat("R2 key2", 1, 1, sh(12'h2AA), 16'h55);
        beat("R3 cmd", 2, 1, sh(12'h555), 16'h90);
        beat("R3 rd0", 3, 0, sh(0), '0);
        beat("R3 rd1", 4, 0, sh(1), '0);
        beat("R3 rd2", 5, 0, sh(14), '0);
        beat("R3 rd3", 6, 0, sh(15), '0);
        chk("R3 word0", 64'(rd_data[0*DW +: DW]), 64'(mem_word(sh(0))));
        chk("R3 word1", 64'(rd_data[1*DW +: DW]), 64'(mem_word(sh(1))));
        chk("R3 word2", 64'(rd_data[2*DW +: DW]), 64'(mem_word(sh(14))));
        chk("R3 word3", 64'(rd_data[3*DW +: DW]), 64'(mem_word(sh(15))));
    endtask

    task automatic t_program;
        wait_cfg = 2;
        send(2, 24'h012345, 16'hBEEF);
        chk("R4 busy", 64'(busy), 64'd1);
        wait_done("R9 program with waits");
        chk("R4 beat count", 64'(lg_n), 64'd4);
        beat("R4 key1", 0, 1, sh(12'h555), 16'hAA);
        beat("R4 key2", 1, 1, sh(12'h2AA), 16'h55);
        beat("R4 cmd", 2, 1, sh(12'h555), 16'hA0);
        beat("R4 data", 3, 1, 24'h012345, 16'hBEEF);
        chk("R4 state back to ready", 64'(state), 64'd1);
    endtask

    task automatic t_erase(input bit chip);
        wait_cfg = 1;
        send(chip ? 4 : 3, 24'h040000, '0);
        wait_done(chip ? "R6 chip" : "R5 block");
        chk(chip ? "R6 beat count" : "R5 beat count", 64'(lg_n), 64'd6);
        beat("R5 key1", 0, 1, sh(12'h555), 16'hAA);
        beat("R5 key2", 1, 1, sh(12'h2AA), 16'h55);
        beat("R5 setup", 2, 1, sh(12'h555), 16'h80);
        beat("R5 key1b", 3, 1, sh(12'h555), 16'hAA);
        beat("R5 key2b", 4, 1, sh(12'h2AA), 16'h55);
        if (chip) beat("R6 final", 5, 1, sh(12'h555), 16'h10);
        else      beat("R5 final", 5, 1, 24'h040000, 16'h30);
    endtask

    task automatic t_rdmode;
        wait_cfg = 0;
        send(1, 24'h00FFFF, 16'h1234);
        wait_done("R7 rdmode");
        chk("R7 beat count", 64'(lg_n), 64'd1);
        beat("R7 write", 0, 1, sh(0), 16'hF0);
    endtask

    task automatic t_query(input string tag, input int exp_state);
        wait_cfg = 1;
        send(5, '0, '0);
        wait_done(tag);
        chk({tag, " R8 beat count"}, 64'(lg_n), 64'd5);
        beat("R8 cmd", 0, 1, sh(12'h055), 16'h98);
        for (int k = 0; k < 4; k++) begin
            beat("R8 rd", k + 1, 0, sh(16 + k), '0);
            chk("R8 word", 64'(rd_data[k*DW +: DW]), 64'(mem_word(sh(16 + k))));
        end
        chk({tag, " final state"}, 64'(state), 64'(exp_state));
    endtask

    task automatic t_busy_reject;
        wait_cfg = 3;
        send(2, 24'h001234, 16'hC0DE);
        req_op = 3'd4; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 reject pulse", 64'(rej), 64'd1);
        @(negedge clk);
        chk("R11 reject one cycle", 64'(rej), 64'd0);
        wait_done("R11 program survives");
        chk("R11 beat count", 64'(lg_n), 64'd4);
        beat("R11 data beat", 3, 1, 24'h001234, 16'hC0DE);
        repeat (4) @(negedge clk);
        chk("R11 no queued op", 64'({busy, lg_n[7:0]}), 64'({1'b0, 8'd4}));
    endtask

    task automatic t_protect;
        wait_cfg = 0;
        send(6, '0, '0);
        chk("R12 lock done", 64'(done), 64'd1);
        chk("R12 protected", 64'(state), 64'd3);
        @(negedge clk);
        send(2, 24'h000100, 16'h1111);
        chk("R12 program err", 64'({err, busy}), 64'({1'b1, 1'b0}));
        @(negedge clk);
        send(3, 24'h000100, '0);
        chk("R12 erase err", 64'({err, busy}), 64'({1'b1, 1'b0}));
        send(4, '0, '0);
        chk("R12 chip err", 64'(err), 64'd1);
        repeat (3) @(negedge clk);
        chk("R12 no beats", 64'(lg_n), 64'd0);
        chk("R12 still protected", 64'(state), 64'd3);
        t_query("R13 query while protected", 3);
        send(1, '0, '0);
        wait_done("R13 rdmode while protected");
        chk("R13 state", 64'(state), 64'd3);
        send(7, '0, '0);
        chk("R12 unlock ready", 64'(state), 64'd1);
        @(negedge clk);
        send(2, 24'h000200, 16'h2222);
        chk("R12 program after unlock", 64'(busy), 64'd1);
        wait_done("R12 program after unlock");
        chk("R12 beats after unlock", 64'(lg_n), 64'd4);
    endtask

    initial begin
        t_reset();
        t_idread();
        t_program();
        t_erase(1'b0);
        t_erase(1'b1);
        t_rdmode();
        t_query("R8 query", 1);
        t_busy_reject();
        t_protect();
        report();
        $finish;
    end

endmodule